// File: doc/BRIEF.md
# Serial ADC sampling frame controller

This block is the digital front end of a serial successive-approximation converter. It watches a serial port made of chip select (active low), frame sync, serial clock and serial data, plus an active-low start input. Each frame is opened either by chip select falling while frame sync is low, or by frame sync rising while chip select is low. The first four data bits, taken MSB first on serial clock rising edges, form a command. The command picks an analog channel, picks one of three self-test levels, writes the configuration, or does nothing.

For an analog command the block opens the sample window once the command is in. In normal mode it closes the window after a fixed number of further serial clocks, short or long as configured. In extended mode the start input holds the window open while it is low, and its rising edge ends the window. When the window closes the block sends a one-cycle start pulse to the SAR engine, drops end-of-conversion, and raises it again when the engine reports done. All inputs are brought into the system clock domain by one register stage, and edges are found there.

Top module: `sar_frame_ctrl`

## Requirements
- R1: After reset, eoc is 1, sample_en is 0, conv_start is 0, mux_sel is 0 and conv_clk_sel is 0. The configuration starts in normal mode, short window, internal conversion clock.
- R2: A frame opens on cs_n falling while fs is low, or on fs rising while cs_n is low. Serial clock edges are ignored while cs_n is high.
- R3: sdi is shifted MSB first on sclk rising edges. The command is the first 4 bits. Codes 0 to 7 select channels 0 to 7. Codes 8, 9 and 10 select the self-test levels. In all these cases mux_sel takes the code and holds it until the next analog command.
- R4: For an analog command, sample_en rises after the 4th sclk rising edge of the frame. In short normal mode it falls at the 16th rising edge, which is 12 edges later.
- R5: In long normal mode the window closes at the 48th rising edge, which is 44 edges later.
- R6: In extended mode the window is open while start_n is low after the command. The rising edge of start_n ends the window and starts the conversion. The sclk count has no effect in this mode.
- R7: When the window closes, conv_start is high for exactly one cycle and eoc goes low. eoc returns high only after conv_done is seen.
- R8: Code 15 is a configuration write. The 5th, 6th and 7th frame bits are taken as the extended-mode flag, the long-window flag and the external conversion clock flag. conv_clk_sel shows the third of these. A configuration frame starts no conversion.
- R9: If cs_n rises before the window closes, the controller returns to idle and does not start a conversion. If cs_n rises in the same cycle as the closing sclk edge, the abort wins.
- R10: While a conversion is running, frame openings and sclk edges are ignored. Codes 11 to 14 open no window and start no conversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| fs | input | 1 | Frame sync |
| sclk | input | 1 | Serial clock, sampled by clk |
| sdi | input | 1 | Serial data in, MSB first |
| start_n | input | 1 | External sample control, active low |
| conv_done | input | 1 | SAR engine finished |
| mux_sel | output | 4 | Selected input or self-test code |
| sample_en | output | 1 | Sample-and-hold window open |
| conv_start | output | 1 | One-cycle start pulse to the SAR engine |
| eoc | output | 1 | End of conversion, low while busy |
| conv_clk_sel | output | 1 | 1 selects the serial clock as the conversion clock |

## Verification
Two events can fall in the same cycle: the sclk edge that closes the sample window, and chip select rising to abort the frame. The bench drives sclk high and cs_n high on the same clock edge after the 15th rising edge of a short frame. It then checks that no conversion pulse was counted and that eoc stayed high. A second collision is also exercised: a frame opening and a run of sclk edges during a conversion. These must leave mux_sel and the pulse count unchanged.

// File: rtl/sar_frame_ctrl.sv
module sar_frame_ctrl #(
  parameter int SHORT_LEN = 12,
  parameter int LONG_LEN  = 44
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       fs,
  input  logic       sclk,
  input  logic       sdi,
  input  logic       start_n,
  input  logic       conv_done,
  output logic [3:0] mux_sel,
  output logic       sample_en,
  output logic       conv_start,
  output logic       eoc,
  output logic       conv_clk_sel
);
  localparam int CMD_W = 4;
  localparam int CW = $clog2(CMD_W + LONG_LEN + 1) + 1;
  localparam logic [CW-1:0] OPEN_CNT  = CW'(CMD_W);
  localparam logic [CW-1:0] SHORT_END = CW'(CMD_W + SHORT_LEN);
  localparam logic [CW-1:0] LONG_END  = CW'(CMD_W + LONG_LEN);
  localparam logic [CW-1:0] CFG_END   = CW'(CMD_W + 3);
  localparam logic [3:0] TEST_LAST = 4'd10;
  localparam logic [3:0] CFG_CODE  = 4'hF;

  typedef enum logic [2:0] {IDLE, SHIFT, SAMPLE, CFGW, HOLD, CONV} st_t;
  st_t state;

  logic cs_s, cs_p, fs_s, fs_p, ck_s, ck_p, di_s, st_s, st_p;
  logic [CW-1:0] cnt;
  logic [2:0] sh;
  logic cfg_ext, cfg_long, cfg_xclk;

  wire ck_rise  = ck_s & ~ck_p & ~cs_s;
  wire st_rise  = st_s & ~st_p;
  wire open_ev  = (~cs_s & cs_p & ~fs_s) | (fs_s & ~fs_p & ~cs_s);
  wire [CW-1:0] cnt_n = cnt + 1'b1;
  wire [3:0] word = {sh, di_s};
  wire [CW-1:0] close_at = cfg_long ? LONG_END : SHORT_END;

  assign sample_en    = (state == SAMPLE) && (!cfg_ext || !st_s);
  assign conv_clk_sel = cfg_xclk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cs_s, cs_p, st_s, st_p} <= 4'b1111;
      {fs_s, fs_p, ck_s, ck_p, di_s} <= 5'b0;
    end else begin
      cs_s <= cs_n;    cs_p <= cs_s;
      fs_s <= fs;      fs_p <= fs_s;
      ck_s <= sclk;    ck_p <= ck_s;
      st_s <= start_n; st_p <= st_s;
      di_s <= sdi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= IDLE;
      cnt        <= '0;
      sh         <= '0;
      mux_sel    <= '0;
      conv_start <= 1'b0;
      eoc        <= 1'b1;
      {cfg_ext, cfg_long, cfg_xclk} <= 3'b000;
    end else begin
      conv_start <= 1'b0;
      case (state)
        IDLE, HOLD: begin
          if (open_ev) begin
            state <= SHIFT;
            cnt   <= '0;
          end else if (state == HOLD && cs_s) begin
            state <= IDLE;
          end
        end
        SHIFT, SAMPLE, CFGW: begin
          if (cs_s) begin
            state <= IDLE;
          end else if (state == SAMPLE && cfg_ext && st_rise) begin
            state      <= CONV;
            conv_start <= 1'b1;
            eoc        <= 1'b0;
          end else if (ck_rise) begin
            cnt <= cnt_n;
            sh  <= word[2:0];
            if (state == SHIFT && cnt_n == OPEN_CNT) begin
              if (word == CFG_CODE) begin
                state <= CFGW;
              end else if (word <= TEST_LAST) begin
                mux_sel <= word;
                state   <= SAMPLE;
              end else begin
                state <= HOLD;
              end
            end else if (state == SAMPLE && !cfg_ext && cnt_n == close_at) begin
              state      <= CONV;
              conv_start <= 1'b1;
              eoc        <= 1'b0;
            end else if (state == CFGW && cnt_n == CFG_END) begin
              {cfg_ext, cfg_long, cfg_xclk} <= {sh[1:0], di_s};
              state <= HOLD;
            end
          end
        end
        CONV: begin
          if (conv_done) begin
            eoc   <= 1'b1;
            state <= IDLE;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

module sar_frame_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] st,
  input logic       sample_en,
  input logic       conv_start,
  input logic       eoc,
  input logic       conv_done
);
  p_pulse_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);
  p_eoc_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !eoc);
  p_from_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> $past(st) == 3'd2);
  p_eoc_by_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> $past(conv_done));
  p_no_sample_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |-> !sample_en);
endmodule

bind sar_frame_ctrl sar_frame_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .st(state), .sample_en(sample_en),
  .conv_start(conv_start), .eoc(eoc), .conv_done(conv_done)
);

// File: tb/sar_frame_ctrl_bench.sv
`timescale 1ns/1ps
module sar_frame_ctrl_bench;
  logic clk = 0, rst_n = 0, cs_n = 1, fs = 0, sclk = 0, sdi = 0, start_n = 1, conv_done = 0;
  logic [3:0] mux_sel;
  logic sample_en, conv_start, eoc, conv_clk_sel;
  int checks = 0, fails = 0, convs = 0;

  always #2.5 clk = ~clk;

  sar_frame_ctrl u_sar_frame_ctrl (.*);

  always @(posedge clk) if (rst_n && conv_start) convs++;

  task automatic tick(int n); repeat (n) @(negedge clk); endtask
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask
  task automatic rise(logic b); sdi = b; sclk = 1; tick(4); sclk = 0; tick(4); endtask
  task automatic open_frame(bit use_fs);
    if (!use_fs) begin fs = 0; cs_n = 0; tick(4); end
    else begin fs = 1; cs_n = 0; tick(4); fs = 0; tick(4); fs = 1; tick(4); end
  endtask
  task automatic close_frame; cs_n = 1; fs = 0; tick(4); endtask
  task automatic send_cmd(logic [3:0] c);
    for (int i = 3; i >= 0; i--) rise(c[i]);
  endtask
  task automatic finish_conv;
    conv_done = 1; tick(1); conv_done = 0; tick(3);
  endtask
  task automatic write_cfg(bit ext, bit lng, bit xclk);
    int c0 = convs;
    open_frame(0); send_cmd(4'hF); rise(ext); rise(lng); rise(xclk); close_frame;
    chk("R8 conv_clk_sel", conv_clk_sel, xclk);
    chk("R8 no conversion", convs, c0);
  endtask

  function automatic int exp_close(bit lng); return lng ? 48 : 16; endfunction
  function automatic bit is_analog(logic [3:0] c); return c <= 4'd10; endfunction

  task automatic normal_frame(logic [3:0] cmd, bit lng, bit use_fs);
    int c0 = convs;
    open_frame(use_fs);
    for (int i = 3; i >= 1; i--) rise(cmd[i]);
    chk("R4 closed before 4th edge", sample_en, 0);
    rise(cmd[0]);
    chk("R4 open after 4th edge", sample_en, 1);
    chk("R3 mux_sel", mux_sel, cmd);
    for (int i = 5; i < exp_close(lng); i++) rise($urandom_range(0, 1));
    chk(lng ? "R5 still open" : "R4 still open", sample_en, 1);
    chk("R7 no early conv", convs, c0);
    rise(0);
    chk(lng ? "R5 closed" : "R4 closed", sample_en, 0);
    chk("R7 one pulse", convs, c0 + 1);
    chk("R7 eoc low", eoc, 0);
    rise(1); close_frame;
    chk("R7 eoc waits done", eoc, 0);
    finish_conv;
    chk("R7 eoc high", eoc, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=1 exp=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int c0;
    void'($urandom(32'd77));
    tick(4); rst_n = 1; tick(2);
    chk("R1 eoc", eoc, 1);
    chk("R1 sample_en", sample_en, 0);
    chk("R1 conv_start", conv_start, 0);
    chk("R1 mux_sel", mux_sel, 0);
    chk("R1 conv_clk_sel", conv_clk_sel, 0);

    // R2: edges with cs_n high are ignored
    for (int i = 0; i < 6; i++) rise(1);
    chk("R2 ignored while deselected", sample_en, 0);
    normal_frame(4'd5, 0, 0);
    normal_frame(4'd9, 0, 1);

    write_cfg(0, 1, 1);
    normal_frame(4'd2, 1, 0);

    // R6 extended mode
    write_cfg(1, 0, 0);
    c0 = convs;
    open_frame(0); send_cmd(4'd3);
    chk("R6 closed while start_n high", sample_en, 0);
    start_n = 0; tick(4);
    chk("R6 open while start_n low", sample_en, 1);
    for (int i = 0; i < 20; i++) rise(0);
    chk("R6 count has no effect", convs, c0);
    start_n = 1; tick(4);
    chk("R6 start_n rise converts", convs, c0 + 1);
    chk("R6 eoc low", eoc, 0);
    close_frame; finish_conv;

    write_cfg(0, 0, 0);

    // R9 abort mid window
    c0 = convs;
    open_frame(0); send_cmd(4'd1); for (int i = 0; i < 4; i++) rise(1);
    close_frame;
    chk("R9 abort no conv", convs, c0);
    chk("R9 abort eoc", eoc, 1);
    chk("R9 abort window", sample_en, 0);
    // R9 abort ties with closing edge
    open_frame(0); send_cmd(4'd6); for (int i = 5; i < 16; i++) rise(0);
    sclk = 1; cs_n = 1; tick(4); sclk = 0; tick(4);
    chk("R9 tie abort wins", convs, c0);
    chk("R9 tie eoc", eoc, 1);

    // R10 reserved code
    open_frame(0); send_cmd(4'd12); for (int i = 0; i < 20; i++) rise(1);
    chk("R10 reserved no window", sample_en, 0);
    chk("R10 reserved no conv", convs, c0);
    chk("R10 reserved mux kept", mux_sel, 6);
    close_frame;

    // R10 busy: frame activity during conversion is ignored
    open_frame(0); send_cmd(4'd4); for (int i = 5; i <= 16; i++) rise(0);
    close_frame;
    c0 = convs;
    open_frame(0); send_cmd(4'd7); for (int i = 0; i < 14; i++) rise(0);
    chk("R10 busy mux kept", mux_sel, 4);
    chk("R10 busy no conv", convs, c0);
    close_frame; finish_conv;
    chk("R10 eoc after busy", eoc, 1);

    // random frames
    for (int n = 0; n < 16; n++) begin
      logic [3:0] cmd = 4'($urandom_range(0, 10));
      bit lng = 1'($urandom_range(0, 1));
      write_cfg(0, lng, 1'($urandom_range(0, 1)));
      if (is_analog(cmd)) normal_frame(cmd, lng, 1'($urandom_range(0, 1)));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule